// File: doc/BRIEF.md
# Register Rename Map Table

This block renames one instruction per cycle for a processor that keeps several loop iterations in flight at once. Each incoming instruction may name up to two architectural source registers and one architectural destination. Each source is replaced by the temporary tag of the most recent instruction that wrote that architectural register. This keeps true dependences intact and removes false conflicts caused by reusing register names.

An instruction that writes a destination receives a fresh temporary tag from a pool of 64. Tags are issued in strictly ascending order, starting at T9 after reset and wrapping modulo 64. The new tag is recorded as the current producer of that architectural register. A free counter tracks how many tags can still be issued, and a release pulse returns one tag to the pool. When the pool is empty, an instruction with a destination is held off through the input handshake. The renamed result appears on registered outputs one cycle after the instruction is accepted.

Top module: `rename_unit`

## Requirements
- R1: After reset every map entry is invalid, the next tag is 9, 55 tags are free, `in_ready` is high, `stall` is low and `out_valid` is low.
- R2: A source whose map entry is valid is output as that entry's tag, with its mapped flag set to 1.
- R3: A source whose map entry is invalid is output as its architectural number zero-extended to 6 bits, with its mapped flag set to 0.
- R4: Each accepted instruction with `in_dst_valid` high receives the next tag in ascending order. After T63 the next tag is T0.
- R5: Sources are looked up before the same instruction's destination updates the table, so a source equal to the destination receives the old mapping.
- R6: An accepted instruction with `in_dst_valid` low allocates no tag and leaves both the map table and the next tag unchanged.
- R7: When no tag is free and `in_dst_valid` is high, `in_ready` is low and `stall` equals `in_valid`. The instruction is not accepted, produces no output and does not change the table.
- R8: Each `rel_valid` pulse adds one free tag, up to 64. A release and an allocation in the same cycle leave the count unchanged. A release arriving while the pool is empty does not lift the stall in that same cycle.
- R9: `out_valid` is high for exactly one cycle, in the cycle after each accepted instruction, and is low at all other times.
- R10: The source valid flags and the destination valid flag and number are carried through to the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_src0_valid | input | 1 | First source used |
| in_src0_arch | input | 5 | First source architectural register |
| in_src1_valid | input | 1 | Second source used |
| in_src1_arch | input | 5 | Second source architectural register |
| in_dst_valid | input | 1 | Instruction writes a destination |
| in_dst_arch | input | 5 | Destination architectural register |
| rel_valid | input | 1 | Return one temporary to the pool |
| stall | output | 1 | Valid instruction blocked because the pool is empty |
| out_valid | output | 1 | Renamed instruction valid |
| out_src0_valid | output | 1 | First source used |
| out_src0_id | output | 6 | First source tag or architectural number |
| out_src0_mapped | output | 1 | First source id is a tag |
| out_src1_valid | output | 1 | Second source used |
| out_src1_id | output | 6 | Second source tag or architectural number |
| out_src1_mapped | output | 1 | Second source id is a tag |
| out_dst_valid | output | 1 | Destination present |
| out_dst_arch | output | 5 | Destination architectural register |
| out_dst_tag | output | 6 | Allocated temporary tag |

## Verification
Two events can fall in the same cycle: a tag release and an allocation. The bench provokes this in two states. When the pool is empty, the release must not admit the waiting instruction in that cycle. When tags are free, the instruction must be accepted and the free count must stay the same. Both outcomes are judged at the ports against a model of the pointer and the count held in the bench. The bench then drains the pool to show the exact number of further grants before the next stall.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned DEF_ARCH_REGS = 32;
  localparam int unsigned DEF_TAGS      = 64;
  localparam int unsigned DEF_FIRST_TAG = 9;
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int unsigned ARCH_REGS = 32,
  parameter int unsigned TAG_W     = 6,
  parameter int unsigned NUM_RD    = 2,
  localparam int unsigned AREG_W   = $clog2(ARCH_REGS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_RD-1:0][AREG_W-1:0] rd_addr,
  output logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag,
  output logic [NUM_RD-1:0]             rd_hit,
  input  logic                          wr_en,
  input  logic [AREG_W-1:0]             wr_addr,
  input  logic [TAG_W-1:0]              wr_tag
);
  logic [TAG_W-1:0]     tag_mem [ARCH_REGS];
  logic [ARCH_REGS-1:0] live;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_addr] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (wr_en) live[wr_addr] <= 1'b1;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_tag[p] = tag_mem[rd_addr[p]];
    assign rd_hit[p] = live[rd_addr[p]];
  end

  // R2: a written entry reads back as valid in the next cycle
  assert_write_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> live[$past(wr_addr)]);
endmodule

// File: rtl/rename_tag_alloc.sv
module rename_tag_alloc #(
  parameter int unsigned TAGS      = 64,
  parameter int unsigned FIRST_TAG = 9,
  localparam int unsigned TAG_W    = $clog2(TAGS),
  localparam int unsigned CNT_W    = $clog2(TAGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             release_one,
  output logic [TAG_W-1:0] next_tag,
  output logic             empty
);
  localparam logic [TAG_W-1:0] START_PTR  = TAG_W'(FIRST_TAG);
  localparam logic [TAG_W-1:0] LAST_PTR   = TAG_W'(TAGS - 1);
  localparam logic [CNT_W-1:0] START_FREE = CNT_W'(TAGS - FIRST_TAG);
  localparam logic [CNT_W-1:0] FULL_FREE  = CNT_W'(TAGS);

  logic [TAG_W-1:0] ptr_q;
  logic [CNT_W-1:0] free_q;
  logic             inc;

  assign next_tag = ptr_q;
  assign empty    = (free_q == '0);
  assign inc      = release_one && (free_q != FULL_FREE);

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= START_PTR;
    else if (alloc) ptr_q <= (ptr_q == LAST_PTR) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= START_FREE;
    else begin
      case ({alloc, inc})
        2'b10:   free_q <= free_q - 1'b1;
        2'b01:   free_q <= free_q + 1'b1;
        default: free_q <= free_q;
      endcase
    end
  end

  // R7: no grant from an empty pool
  assert_no_alloc_empty_R7: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !empty);
  // R8: count never exceeds the pool size
  assert_free_bound_R8: assert property (@(posedge clk) disable iff (rst)
    free_q <= FULL_FREE);
  // R8: a simultaneous grant and release leave the count unchanged
  assert_swap_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
    (alloc && release_one) |=> $stable(free_q));
  // R6: the pointer holds when there is no grant
  assert_ptr_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !alloc |=> $stable(ptr_q));
endmodule

// File: rtl/rename_out_stage.sv
module rename_out_stage #(
  parameter int unsigned AREG_W = 5,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [1:0]        src_valid,
  input  logic [1:0][ID_W-1:0] src_id,
  input  logic [1:0]        src_mapped,
  input  logic              dst_valid,
  input  logic [AREG_W-1:0] dst_arch,
  input  logic [TAG_W-1:0]  dst_tag,
  output logic              q_valid,
  output logic [1:0]        q_src_valid,
  output logic [1:0][ID_W-1:0] q_src_id,
  output logic [1:0]        q_src_mapped,
  output logic              q_dst_valid,
  output logic [AREG_W-1:0] q_dst_arch,
  output logic [TAG_W-1:0]  q_dst_tag
);
  always_ff @(posedge clk) begin
    if (rst) q_valid <= 1'b0;
    else     q_valid <= fire;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      q_src_valid  <= src_valid;
      q_src_id     <= src_id;
      q_src_mapped <= src_mapped;
      q_dst_valid  <= dst_valid;
      q_dst_arch   <= dst_arch;
      q_dst_tag    <= dst_valid ? dst_tag : '0;
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
#(
  parameter int unsigned ARCH_REGS = DEF_ARCH_REGS,
  parameter int unsigned TAGS      = DEF_TAGS,
  parameter int unsigned FIRST_TAG = DEF_FIRST_TAG,
  localparam int unsigned AREG_W   = $clog2(ARCH_REGS),
  localparam int unsigned TAG_W    = $clog2(TAGS),
  localparam int unsigned ID_W     = (TAG_W > AREG_W) ? TAG_W : AREG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_src0_valid,
  input  logic [AREG_W-1:0] in_src0_arch,
  input  logic              in_src1_valid,
  input  logic [AREG_W-1:0] in_src1_arch,
  input  logic              in_dst_valid,
  input  logic [AREG_W-1:0] in_dst_arch,
  input  logic              rel_valid,
  output logic              stall,
  output logic              out_valid,
  output logic              out_src0_valid,
  output logic [ID_W-1:0]   out_src0_id,
  output logic              out_src0_mapped,
  output logic              out_src1_valid,
  output logic [ID_W-1:0]   out_src1_id,
  output logic              out_src1_mapped,
  output logic              out_dst_valid,
  output logic [AREG_W-1:0] out_dst_arch,
  output logic [TAG_W-1:0]  out_dst_tag
);
  logic [1:0][AREG_W-1:0] rd_addr;
  logic [1:0][TAG_W-1:0]  rd_tag;
  logic [1:0]             rd_hit;
  logic [1:0][ID_W-1:0]   src_id;
  logic [1:0]             q_sv, q_sm;
  logic [1:0][ID_W-1:0]   q_sid;
  logic [TAG_W-1:0]       next_tag;
  logic                   empty, fire, grant;

  assign in_ready = !(in_dst_valid && empty);
  assign stall    = in_valid && in_dst_valid && empty;
  assign fire     = in_valid && in_ready;
  assign grant    = fire && in_dst_valid;

  assign rd_addr[0] = in_src0_arch;
  assign rd_addr[1] = in_src1_arch;

  rename_map_table #(.ARCH_REGS(ARCH_REGS), .TAG_W(TAG_W), .NUM_RD(2)) table_i (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_tag(rd_tag), .rd_hit(rd_hit),
    .wr_en(grant), .wr_addr(in_dst_arch), .wr_tag(next_tag)
  );

  rename_tag_alloc #(.TAGS(TAGS), .FIRST_TAG(FIRST_TAG)) alloc_i (
    .clk(clk), .rst(rst), .alloc(grant), .release_one(rel_valid),
    .next_tag(next_tag), .empty(empty)
  );

  for (genvar s = 0; s < 2; s++) begin : g_src
    assign src_id[s] = rd_hit[s] ? ID_W'(rd_tag[s]) : ID_W'(rd_addr[s]);
  end

  rename_out_stage #(.AREG_W(AREG_W), .ID_W(ID_W), .TAG_W(TAG_W)) out_i (
    .clk(clk), .rst(rst), .fire(fire),
    .src_valid({in_src1_valid, in_src0_valid}), .src_id(src_id), .src_mapped(rd_hit),
    .dst_valid(in_dst_valid), .dst_arch(in_dst_arch), .dst_tag(next_tag),
    .q_valid(out_valid), .q_src_valid(q_sv), .q_src_id(q_sid), .q_src_mapped(q_sm),
    .q_dst_valid(out_dst_valid), .q_dst_arch(out_dst_arch), .q_dst_tag(out_dst_tag)
  );

  assign out_src0_valid  = q_sv[0];
  assign out_src1_valid  = q_sv[1];
  assign out_src0_id     = q_sid[0];
  assign out_src1_id     = q_sid[1];
  assign out_src0_mapped = q_sm[0];
  assign out_src1_mapped = q_sm[1];

  // R9: one output one cycle after each acceptance
  assert_out_follows_fire_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  assert_no_spurious_out_R9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !out_valid);
  // R7: a stalled instruction is never accepted
  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    stall |-> !in_ready);
endmodule

// File: tb/rename_unit_tb_top.sv
module rename_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 32;
  localparam int NT = 64;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_src0_valid = 0, in_src1_valid = 0, in_dst_valid = 0, rel_valid = 0;
  logic [4:0] in_src0_arch = 0, in_src1_arch = 0, in_dst_arch = 0;
  logic in_ready, stall, out_valid, out_src0_valid, out_src0_mapped, out_src1_valid, out_src1_mapped;
  logic out_dst_valid;
  logic [5:0] out_src0_id, out_src1_id, out_dst_tag;
  logic [4:0] out_dst_arch;

  int tests = 0, fails = 0;
  bit done = 0;
  int mtag[NA];
  bit mval[NA];
  int ptr, freec;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_unit dut_i (.*);

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic op(string req, bit s0v, int s0, bit s1v, int s1, bit dv, int d, bit rel);
    bit acc;
    int e0, e1, em0, em1, etag, f;
    in_valid = 1; in_src0_valid = s0v; in_src0_arch = 5'(s0);
    in_src1_valid = s1v; in_src1_arch = 5'(s1);
    in_dst_valid = dv; in_dst_arch = 5'(d); rel_valid = rel;
    acc = !(dv && freec == 0);
    e0 = mval[s0] ? mtag[s0] : s0; em0 = mval[s0];
    e1 = mval[s1] ? mtag[s1] : s1; em1 = mval[s1];
    etag = ptr;
    #1;
    chk(req, "in_ready", in_ready, acc);
    chk(req, "stall", stall, !acc);
    @(posedge clk);
    f = freec;
    if (acc && dv) begin
      mtag[d] = ptr; mval[d] = 1; ptr = (ptr + 1) % NT; f--;
    end
    if (rel && freec < NT) f++;
    freec = f;
    @(negedge clk);
    chk(req, "R9 out_valid", out_valid, acc);
    if (acc) begin
      chk(req, "src0 id", out_src0_id, e0);
      chk(req, "src0 mapped", out_src0_mapped, em0);
      chk(req, "src1 id", out_src1_id, e1);
      chk(req, "src1 mapped", out_src1_mapped, em1);
      chk("R10", "src valids", {out_src1_valid, out_src0_valid}, {s1v, s0v});
      chk("R10", "dst valid", out_dst_valid, dv);
      if (dv) begin
        chk(req, "dst tag", out_dst_tag, etag);
        chk("R10", "dst arch", out_dst_arch, d);
      end
    end
    in_valid = 0; rel_valid = 0; in_dst_valid = 0;
  endtask

  task automatic rel_only();
    rel_valid = 1;
    @(posedge clk);
    if (freec < NT) freec++;
    @(negedge clk);
    rel_valid = 0;
    chk("R9", "no output on release", out_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NA; i++) begin mval[i] = 0; mtag[i] = 0; end
    ptr = 9; freec = 55;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1", "ready after reset", in_ready, 1);
    chk("R1", "stall after reset", stall, 0);
    chk("R1", "out_valid after reset", out_valid, 0);
    // R3: every register unmapped; R6 no destination
    for (int r = 0; r < NA; r++) op("R3", r[0], r, !r[0], NA-1-r, 0, 0, 0);
    // R1/R4: first grant is T9; R5 source equal to dest sees old; R2 mapped reads
    op("R1", 1, 0, 1, 0, 1, 0, 0);
    for (int r = 1; r < NA; r++) op("R5", 1, r, 1, r-1, 1, r, 0);
    for (int r = 0; r < NA; r++) op("R2", 1, r, 1, (r*7) % NA, 0, 0, 0);
    // R6: no-dest between grants keeps pointer
    op("R6", 1, 3, 0, 4, 0, 3, 0);
    // R4: drain the pool, overwriting mappings
    for (int k = 0; freec > 0; k++) op("R4", 1, k % NA, 1, (k+5) % NA, 1, k % NA, 0);
    // R7: stall and no table change
    op("R7", 1, 5, 1, 6, 1, 5, 0);
    op("R7", 1, 5, 1, 6, 0, 0, 0);
    // R8: release with an empty pool does not admit this cycle
    op("R8", 1, 7, 1, 8, 1, 7, 1);
    // R4 wrap: next grant is T0
    op("R4", 1, 7, 1, 8, 1, 7, 0);
    op("R7", 1, 1, 1, 2, 1, 9, 0);
    rel_only(); rel_only();
    // R8: grant with release in the same cycle keeps the count at 2
    op("R8", 1, 9, 1, 7, 1, 9, 1);
    op("R8", 1, 9, 1, 7, 1, 10, 0);
    op("R8", 1, 10, 1, 9, 1, 11, 0);
    op("R8", 1, 11, 1, 10, 1, 12, 0);
    // R8: saturating releases then a long run of grants
    for (int i = 0; i < NT + 4; i++) rel_only();
    for (int k = 0; k < NT + 2; k++) op("R4", 1, k % NA, 1, (k+3) % NA, 1, (k*11) % NA, 0);
    finish_run();
  end
endmodule